// File: doc/BRIEF.md
# Chainable Serial Result Readout Port

This block is the digital readout side of a data converter. When the conversion engine signals that a result is ready, the port stores the result word, raises a data-valid flag and moves the word into an output shift register. The shift register runs on its own data clock. A host clocks bits out of it, most significant bit first, while it holds transmit-enable high. Two word formats are available: a 21-bit two's-complement word, and a 20-bit straight-binary word made from the low twenty bits of the result.

The serial input feeds the tail of the shift register, so the same register also passes data through. When several ports are chained, each one's serial output drives the next one's serial input. All the devices then share one transmit-enable line and one data line, and the words come out one after another. The tail tap follows the selected format, so each device in the chain adds exactly one word length.

Two overflow flags, one for positive and one for negative full-scale excursions, collect overflow events during a conversion. They are presented as open-drain pull-down enables so that they can be wire-ORed. They clear on the falling system-clock edge that follows the rise of data-valid, so an external register clocked by data-valid still sees them. The serial output is presented as a data bit plus a pad drive enable, which stands for the tri-state pin.

Top module: `chain_readout_port`

## Requirements
- R1: While `rst_n` is low and after its release, before any conversion, `dvalid`, `ovf_pos_pd` and `ovf_neg_pd` are 0 and the output register is all zeros (`sdo` reads 0 once transmit-enable is raised).
- R2: With `fmt_twos`=1, the 21-bit `conv_result` leaves `sdo` MSB first, exactly 21 bits before upstream data.
- R3: With `fmt_twos`=0, `conv_result[19:0]` leaves `sdo` MSB first, exactly 20 bits before upstream data, and `conv_result[20]` is never sent.
- R4: The output register shifts by one bit on each rising `dclk` edge at which `xmit_en` is 1 and holds its contents on every other edge, so a transmission that pauses resumes with the next bit.
- R5: `sdo_oe` is 1 exactly while `xmit_en` is 1; otherwise the serial pad is released (high impedance).
- R6: A bit sampled from `sdi` at the k-th shift (k counted from 0) appears on `sdo` as stream bit W+k, where W is the word length (21 or 20) of the selected format.
- R7: `dvalid` becomes 1 at the rising `sys_clk` edge that samples `conv_done`=1.
- R8: `dvalid` stays 1 until `xmit_en` is seen high, and returns to 0 within three `sys_clk` edges after that.
- R9: A pulse on `conv_ovf_pos` or `conv_ovf_neg` during a conversion sets only the matching pull-down output `ovf_pos_pd` or `ovf_neg_pd` to 1.
- R10: The overflow pull-downs are still 1 just after the `sys_clk` edge at which `dvalid` rises, and are 0 after the following falling `sys_clk` edge.
- R11: A later conversion replaces the output word; it is loaded into the output register within three `dclk` rising edges after its `conv_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Conversion (system) clock |
| dclk | input | 1 | Data clock for serial shifting, independent of `sys_clk` |
| rst_n | input | 1 | Asynchronous active-low system reset |
| fmt_twos | input | 1 | Format: 1 = 21-bit two's complement, 0 = 20-bit straight binary |
| conv_done | input | 1 | One-cycle conversion-complete strobe (`sys_clk`) |
| conv_result | input | 21 | Result word, valid with `conv_done` |
| conv_ovf_pos | input | 1 | Positive full-scale excursion seen during conversion |
| conv_ovf_neg | input | 1 | Negative full-scale excursion seen during conversion |
| xmit_en | input | 1 | Transmit enable, synchronous to `dclk` |
| sdi | input | 1 | Serial chain input from the upstream device |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Serial pad drive enable (0 = high impedance) |
| dvalid | output | 1 | Data-valid flag |
| ovf_pos_pd | output | 1 | Open-drain pull-down enable for the positive overflow line |
| ovf_neg_pd | output | 1 | Open-drain pull-down enable for the negative overflow line |

## Verification
The bench aims at the chain boundary in both formats. If the tail tap were left at bit 0 in 20-bit mode, each upstream bit would arrive one position late, and the stream would contain 21 bits per device and a stray padding bit. It pauses a transmission partway through to show that bits are neither dropped nor repeated while `xmit_en` is low. It also checks that the pad is released during the pause. It checks the overflow flags on both sides of the half-cycle clear: a flag cleared on the rising edge would already read 0 at the data-valid edge, and a flag never cleared would stay 1. It also lets a second conversion overwrite the first, which catches a load strobe lost in the clock crossing.

// File: rtl/crp_pkg.sv
`timescale 1ns/1ps
package crp_pkg;
  localparam int TWOS_W = 21;
  localparam int BIN_W  = 20;
  localparam int SYNC_N = 2;
  typedef enum logic {FMT_BIN = 1'b0, FMT_TWOS = 1'b1} fmt_e;
endpackage

// File: rtl/crp_sync.sv
`timescale 1ns/1ps
module crp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/crp_capture.sv
`timescale 1ns/1ps
module crp_capture #(
  parameter int RES_W  = crp_pkg::TWOS_W,
  parameter int SYNC_N = crp_pkg::SYNC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  input  logic             ovf_pos_in,
  input  logic             ovf_neg_in,
  input  logic             xmit_en,
  output logic             dvalid,
  output logic [RES_W-1:0] hold_word,
  output logic             load_tog,
  output logic             ovf_pos,
  output logic             ovf_neg
);
  logic             xmit_s;
  logic             dv_q, dv_d, dv_prev_q;
  logic [RES_W-1:0] hold_q, hold_d;
  logic             tog_q, tog_d;
  logic             op_q, op_d, on_q, on_d;
  logic             dv_rise;

  crp_sync #(.STAGES(SYNC_N)) u_xmit_sync (
    .clk(clk), .rst_n(rst_n), .d(xmit_en), .q(xmit_s)
  );

  always_comb begin
    dv_d = dv_q;
    if (conv_done)   dv_d = 1'b1;
    else if (xmit_s) dv_d = 1'b0;
    hold_d = conv_done ? conv_result : hold_q;
    tog_d  = tog_q ^ conv_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q      <= 1'b0;
      dv_prev_q <= 1'b0;
      hold_q    <= '0;
      tog_q     <= 1'b0;
    end else begin
      dv_q      <= dv_d;
      dv_prev_q <= dv_q;
      hold_q    <= hold_d;
      tog_q     <= tog_d;
    end
  end

  // overflow flags live on the falling edge so they clear half a cycle after dvalid rises
  assign dv_rise = dv_q & ~dv_prev_q;

  always_comb begin
    op_d = dv_rise ? 1'b0 : (op_q | ovf_pos_in);
    on_d = dv_rise ? 1'b0 : (on_q | ovf_neg_in);
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= 1'b0;
      on_q <= 1'b0;
    end else begin
      op_q <= op_d;
      on_q <= on_d;
    end
  end

  assign dvalid    = dv_q;
  assign hold_word = hold_q;
  assign load_tog  = tog_q;
  assign ovf_pos   = op_q;
  assign ovf_neg   = on_q;

  a_r7_dvalid_set: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> dv_q);
  a_r7_dvalid_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dv_q) |-> $past(conv_done));
  a_r8_dvalid_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (xmit_s && !conv_done) |=> !dv_q);
  a_r10_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dv_q) |-> (!op_q && !on_q));
endmodule

// File: rtl/crp_shifter.sv
`timescale 1ns/1ps
module crp_shifter #(
  parameter int RES_W  = crp_pkg::TWOS_W,
  parameter int SYNC_N = crp_pkg::SYNC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_tog,
  input  logic [RES_W-1:0] hold_word,
  input  logic             fmt_twos,
  input  logic             xmit_en,
  input  logic             sdi,
  output logic             sdo,
  output logic             sdo_oe
);
  logic             tog_s, tog_prev_q;
  logic             load;
  logic [RES_W-1:0] sr_q, sr_d;

  crp_sync #(.STAGES(SYNC_N)) u_load_sync (
    .clk(clk), .rst_n(rst_n), .d(load_tog), .q(tog_s)
  );

  assign load = tog_s ^ tog_prev_q;

  always_comb begin
    sr_d = sr_q;
    if (load) begin
      if (fmt_twos == crp_pkg::FMT_TWOS) sr_d = hold_word;
      else                               sr_d = {hold_word[RES_W-2:0], 1'b0};
    end else if (xmit_en) begin
      // chain tail moves up one place in the shorter format
      if (fmt_twos == crp_pkg::FMT_TWOS) sr_d = {sr_q[RES_W-2:0], sdi};
      else                               sr_d = {sr_q[RES_W-2:1], sdi, 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_prev_q <= 1'b0;
      sr_q       <= '0;
    end else begin
      tog_prev_q <= tog_s;
      sr_q       <= sr_d;
    end
  end

  assign sdo    = sr_q[RES_W-1];
  assign sdo_oe = xmit_en;

  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!xmit_en && !load) |=> $stable(sr_q));
  a_r6_chain_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (xmit_en && !load && fmt_twos) |=> (sr_q[0] == $past(sdi)));
  a_r4_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    (xmit_en && !load) |=> (sr_q[RES_W-1] == $past(sr_q[RES_W-2])));
endmodule

// File: rtl/chain_readout_port.sv
`timescale 1ns/1ps
module chain_readout_port #(
  parameter int RES_W  = crp_pkg::TWOS_W,
  parameter int SYNC_N = crp_pkg::SYNC_N
) (
  input  logic             sys_clk,
  input  logic             dclk,
  input  logic             rst_n,
  input  logic             fmt_twos,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  input  logic             conv_ovf_pos,
  input  logic             conv_ovf_neg,
  input  logic             xmit_en,
  input  logic             sdi,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             dvalid,
  output logic             ovf_pos_pd,
  output logic             ovf_neg_pd
);
  logic             rst_sys_n, rst_dck_n;
  logic [RES_W-1:0] hold_word;
  logic             load_tog;

  crp_sync #(.STAGES(SYNC_N)) u_rst_sys (
    .clk(sys_clk), .rst_n(rst_n), .d(1'b1), .q(rst_sys_n)
  );
  crp_sync #(.STAGES(SYNC_N)) u_rst_dck (
    .clk(dclk), .rst_n(rst_n), .d(1'b1), .q(rst_dck_n)
  );

  crp_capture #(.RES_W(RES_W), .SYNC_N(SYNC_N)) u_capture (
    .clk(sys_clk), .rst_n(rst_sys_n), .conv_done(conv_done),
    .conv_result(conv_result), .ovf_pos_in(conv_ovf_pos),
    .ovf_neg_in(conv_ovf_neg), .xmit_en(xmit_en), .dvalid(dvalid),
    .hold_word(hold_word), .load_tog(load_tog),
    .ovf_pos(ovf_pos_pd), .ovf_neg(ovf_neg_pd)
  );

  crp_shifter #(.RES_W(RES_W), .SYNC_N(SYNC_N)) u_shifter (
    .clk(dclk), .rst_n(rst_dck_n), .load_tog(load_tog),
    .hold_word(hold_word), .fmt_twos(fmt_twos), .xmit_en(xmit_en),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
  );
endmodule

// File: tb/chain_readout_port_test.sv
`timescale 1ns/1ps
module chain_readout_port_test;
  localparam int SYS_PERIOD = 10;
  localparam int DCK_PERIOD = 14;

  logic        sys_clk = 0, dclk = 0, rst_n = 0;
  logic        fmt_twos = 1, conv_done = 0, conv_ovf_pos = 0, conv_ovf_neg = 0;
  logic        xmit_en = 0, sdi = 0;
  logic [20:0] conv_result = '0;
  logic        sdo, sdo_oe, dvalid, ovf_pos_pd, ovf_neg_pd;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #(SYS_PERIOD/2) sys_clk = ~sys_clk;
  always #(DCK_PERIOD/2) dclk = ~dclk;

  chain_readout_port uut (
    .sys_clk(sys_clk), .dclk(dclk), .rst_n(rst_n), .fmt_twos(fmt_twos),
    .conv_done(conv_done), .conv_result(conv_result),
    .conv_ovf_pos(conv_ovf_pos), .conv_ovf_neg(conv_ovf_neg),
    .xmit_en(xmit_en), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
    .dvalid(dvalid), .ovf_pos_pd(ovf_pos_pd), .ovf_neg_pd(ovf_neg_pd)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic convert(input logic [20:0] v);
    @(posedge sys_clk); #1;
    conv_result = v; conv_done = 1;
    @(posedge sys_clk); #1;
    conv_done = 0;
    check("R7 dvalid after conversion", 64'(dvalid), 64'd1);
    repeat (6) @(posedge dclk);
  endtask

  // shifts nbits, feeding upw (width upw_w) MSB first into sdi; optional pause
  task automatic frame(input int nbits, input logic [20:0] upw, input int upw_w,
                       input int pause_at, output logic [63:0] got);
    got = '0;
    @(negedge dclk);
    for (int i = 0; i < nbits; i++) begin
      if (i == pause_at) begin
        xmit_en = 0;
        repeat (6) @(negedge dclk);
        #1 check("R5 pad released during pause", 64'(sdo_oe), 64'd0);
        xmit_en = 1;
      end
      xmit_en = 1;
      sdi = (i < upw_w) ? upw[upw_w-1-i] : 1'b0;
      #1;
      if (i == 0) check("R5 pad driven while enabled", 64'(sdo_oe), 64'd1);
      got = {got[62:0], sdo};
      @(negedge dclk);
    end
    xmit_en = 0; sdi = 0;
    #1 check("R5 pad released after frame", 64'(sdo_oe), 64'd0);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge sys_clk);
    #1;
    check("R1 dvalid in reset", 64'(dvalid), 64'd0);
    check("R1 ovf pulldowns in reset", {62'd0, ovf_pos_pd, ovf_neg_pd}, 64'd0);
    rst_n = 1;
    repeat (4) @(posedge dclk);
    repeat (4) @(posedge sys_clk);
    #1;
    check("R1 dvalid after release", 64'(dvalid), 64'd0);
    check("R5 pad released at idle", 64'(sdo_oe), 64'd0);
    @(negedge dclk); xmit_en = 1; #1;
    check("R1 cleared register sdo", 64'(sdo), 64'd0);
    xmit_en = 0;
    repeat (4) @(posedge sys_clk);
  endtask

  task automatic t_twos();
    logic [63:0] got;
    fmt_twos = 1;
    convert(21'h1A5C3E);
    check("R8 dvalid held before transmit", 64'(dvalid), 64'd1);
    frame(42, 21'h0F0F1, 21, -1, got);
    check("R2 R6 twos word then upstream", got, {22'd0, 21'h1A5C3E, 21'h0F0F1});
    repeat (4) @(posedge sys_clk); #1;
    check("R8 dvalid cleared by transmit", 64'(dvalid), 64'd0);
  endtask

  task automatic t_binary();
    logic [63:0] got;
    fmt_twos = 0;
    convert(21'h1ABCDE);
    frame(40, 21'h05A5A, 20, -1, got);
    check("R3 R6 binary word then upstream", got, {24'd0, 20'hABCDE, 20'h05A5A});
    fmt_twos = 1;
  endtask

  task automatic t_pause();
    logic [63:0] got;
    fmt_twos = 1;
    convert(21'h0B3D71);
    frame(42, 21'h12345, 21, 9, got);
    check("R4 pause and resume", got, {22'd0, 21'h0B3D71, 21'h12345});
  endtask

  task automatic t_overflow();
    @(posedge sys_clk); #1 conv_ovf_neg = 1;
    @(posedge sys_clk); #1 conv_ovf_neg = 0;
    check("R9 negative flag set", {62'd0, ovf_pos_pd, ovf_neg_pd}, 64'd1);
    @(posedge sys_clk); #1 conv_ovf_pos = 1;
    @(posedge sys_clk); #1 conv_ovf_pos = 0;
    check("R9 both flags set", {62'd0, ovf_pos_pd, ovf_neg_pd}, 64'd3);
    conv_result = 21'h00042; conv_done = 1;
    @(posedge sys_clk); #1;
    conv_done = 0;
    check("R10 flags visible at dvalid rise", {61'd0, dvalid, ovf_pos_pd, ovf_neg_pd}, 64'd7);
    @(negedge sys_clk); #1;
    check("R10 flags cleared half cycle later", {62'd0, ovf_pos_pd, ovf_neg_pd}, 64'd0);
    @(negedge dclk); xmit_en = 1;
    repeat (2) @(negedge dclk);
    xmit_en = 0;
    repeat (4) @(posedge sys_clk);
  endtask

  task automatic t_reload();
    logic [63:0] got;
    fmt_twos = 1;
    convert(21'h111111);
    convert(21'h0ACE55);
    frame(21, 21'h0, 21, -1, got);
    check("R11 later conversion replaces word", got, {43'd0, 21'h0ACE55});
  endtask

  initial begin
    t_reset();
    t_twos();
    t_binary();
    t_pause();
    t_overflow();
    t_reload();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(SYS_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule